// File: doc/BRIEF.md
# Single-Operand Instruction Executor

This block carries out the one-operand instruction group of a 16-bit register-based microcontroller core. The surrounding core hands it an opcode, the operand value it has already fetched, and the current program counter (PC), stack pointer (SP) and status word. The block returns the rewritten operand, the new status word, PC and SP. For the stack instructions it also issues word-wide requests on a single-port memory.

A three-bit field at opcode bits 9..7 selects the operation. Four codes are pure datapath operations: rotate right through carry, byte swap, arithmetic shift right and sign extend. Three codes are stack sequences: push, call and return-from-interrupt. The last code is illegal. A pulse on `start` while the block is idle launches one instruction. The block then raises `done` for exactly one cycle once every register update is complete. It raises `error` together with `done` when the code was illegal.

The datapath operations finish in two cycles. Each memory access adds one request/acknowledge round trip.

Top module: `sop_exec`

## Requirements
- R1: The operation is chosen only by opcode bits 9..7 (0 rotate-through-carry, 1 byte swap, 2 arithmetic shift right, 3 sign extend, 4 push, 5 call, 6 return-from-interrupt, 7 illegal). All other opcode bits have no effect on any output.
- R2: Code 0 returns the operand shifted right by one, with the incoming carry (status bit 0) placed in bit 15. The old bit 0 becomes the new carry.
- R3: Code 1 returns the operand with its two bytes exchanged, and the status word is passed through unchanged.
- R4: Code 2 returns the operand shifted right by one with bit 15 kept. The old bit 0 becomes the carry.
- R5: Code 3 copies bit 7 into bits 15..8. The carry is set exactly when the result is nonzero.
- R6: Codes 0, 2 and 3 rewrite the whole status word. Carry goes to bit 0, zero-result to bit 1 and result bit 15 to bit 2 (negative). Every other bit reads 0, including the overflow bit 8.
- R7: Code 4 makes one write of the operand to address SP-2 and reports SP-2 as the new SP.
- R8: Code 5 makes one write of the current PC to address SP-2, then reports the operand as the new PC and SP-2 as the new SP.
- R9: Code 6 reads the status word from address SP, then reads the PC from address SP+2, and reports SP+4 as the new SP.
- R10: Code 7 raises `error` together with `done` and makes no memory access. It reports PC, SP and status unchanged and does not assert `result_we`.
- R11: A memory request holds its address, direction and data until it is acknowledged. `done` is a one-cycle pulse that comes one cycle after the final register update.
- R12: During and after reset, `done`, `error` and `mem_req` are low. While idle, no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one instruction (taken while idle) |
| opcode | input | 16 | Instruction word; bits 9..7 select the operation |
| operand_in | input | 16 | Resolved operand value |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| sr_in | input | 16 | Current status word |
| result | output | 16 | New operand value |
| result_we | output | 1 | With `done`: `result` is to be written back |
| sr_out | output | 16 | Status word after the instruction |
| pc_out | output | 16 | Program counter after the instruction |
| sp_out | output | 16 | Stack pointer after the instruction |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | With `done`: the code was illegal |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address of the word access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access acknowledge |

## Verification
A wrong sequencer state shows at the memory port first. A request appears too early, too late, with the wrong direction or with a mis-stepped address, and that is visible in the cycle right after `start` or after the first acknowledge. A wrong datapath or latched value shows when `done` rises as a bad `result`, status, PC or SP. For an ALU code that is two cycles after `start`. A stuck state shows as a missing or repeated `done` pulse and a mismatch in the count of memory accesses per instruction.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // status word flag positions
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 8;

  typedef enum logic [2:0] {
    OP_RRC  = 3'd0,
    OP_SWAP = 3'd1,
    OP_RRA  = 3'd2,
    OP_SXT  = 3'd3,
    OP_PUSH = 3'd4,
    OP_CALL = 3'd5,
    OP_RETI = 3'd6,
    OP_BAD  = 3'd7
  } sop_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RD_SR,
    ST_RD_PC,
    ST_FIN
  } sop_state_e;
endpackage

// File: rtl/sop_alu.sv
module sop_alu
  import sop_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  sop_code_e         code,
  input  logic [DW-1:0]     operand,
  input  logic              carry_in,
  output logic [DW-1:0]     res,
  output logic [DW-1:0]     flags,
  output logic              sets_flags
);
  localparam int unsigned HALF = DW / 2;

  logic cy;

  always_comb begin
    res        = operand;
    cy         = 1'b0;
    sets_flags = 1'b0;
    unique case (code)
      OP_RRC: begin
        res        = {carry_in, operand[DW-1:1]};
        cy         = operand[0];
        sets_flags = 1'b1;
      end
      OP_SWAP: begin
        res = {operand[HALF-1:0], operand[DW-1:HALF]};
      end
      OP_RRA: begin
        res        = {operand[DW-1], operand[DW-1:1]};
        cy         = operand[0];
        sets_flags = 1'b1;
      end
      OP_SXT: begin
        res        = {{HALF{operand[HALF-1]}}, operand[HALF-1:0]};
        cy         = |res;
        sets_flags = 1'b1;
      end
      default: begin
        res = operand;
      end
    endcase
    // whole word rebuilt: V and undefined bits read zero
    flags        = '0;
    flags[FLG_C] = cy;
    flags[FLG_Z] = (res == '0);
    flags[FLG_N] = res[DW-1];
  end
endmodule

// File: rtl/sop_seq.sv
module sop_seq
  import sop_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  sop_code_e     code,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] sr_in,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] alu_flags,
  input  logic          alu_sets,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] result,
  output logic          result_we,
  output logic [DW-1:0] sr_out,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic          done,
  output logic          error,
  output logic          busy
);
  localparam int unsigned STEP = DW / 8;
  localparam logic [DW-1:0] WSTEP = DW'(STEP);

  sop_state_e    state_q, state_d;
  sop_code_e     code_q, code_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [DW-1:0] res_q, res_d;
  logic [DW-1:0] sr_q, sr_d;
  logic [DW-1:0] pc_q, pc_d;
  logic [DW-1:0] sp_q, sp_d;
  logic          rwe_q, rwe_d;
  logic          err_q, err_d;
  logic          accept;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    res_d   = res_q;
    sr_d    = sr_q;
    pc_d    = pc_q;
    sp_d    = sp_q;
    rwe_d   = rwe_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          code_d = code;
          res_d  = operand;
          sr_d   = sr_in;
          pc_d   = pc_in;
          sp_d   = sp_in;
          rwe_d  = 1'b0;
          err_d  = 1'b0;
          unique case (code)
            OP_RRC, OP_SWAP, OP_RRA, OP_SXT: begin
              res_d   = alu_res;
              sr_d    = alu_sets ? alu_flags : sr_in;
              rwe_d   = 1'b1;
              state_d = ST_FIN;
            end
            OP_PUSH, OP_CALL: begin
              sp_d    = sp_in - WSTEP;
              addr_d  = sp_in - WSTEP;
              wdat_d  = (code == OP_CALL) ? pc_in : operand;
              state_d = ST_WRITE;
            end
            OP_RETI: begin
              addr_d  = sp_in;
              state_d = ST_RD_SR;
            end
            default: begin
              err_d   = 1'b1;
              state_d = ST_FIN;
            end
          endcase
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (code_q == OP_CALL) pc_d = res_q;
          state_d = ST_FIN;
        end
      end
      ST_RD_SR: begin
        if (mem_ack) begin
          sr_d    = mem_rdata;
          addr_d  = addr_q + WSTEP;
          state_d = ST_RD_PC;
        end
      end
      ST_RD_PC: begin
        if (mem_ack) begin
          pc_d    = mem_rdata;
          sp_d    = sp_q + (WSTEP << 1);
          state_d = ST_FIN;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= OP_RRC;
      addr_q  <= '0;
      wdat_q  <= '0;
      res_q   <= '0;
      sr_q    <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      rwe_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      res_q   <= res_d;
      sr_q    <= sr_d;
      pc_q    <= pc_d;
      sp_q    <= sp_d;
      rwe_q   <= rwe_d;
      err_q   <= err_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_WRITE) || (state_q == ST_RD_SR) || (state_q == ST_RD_PC);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign done      = (state_q == ST_FIN);
  assign error     = done && err_q;
  assign result_we = done && rwe_q;
  assign result    = res_q;
  assign sr_out    = sr_q;
  assign pc_out    = pc_q;
  assign sp_out    = sp_q;
endmodule

// File: rtl/sop_exec.sv
module sop_exec
  import sop_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned OPW    = 16,
  parameter int unsigned OP_LSB = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  operand_in,
  input  logic [DW-1:0]  pc_in,
  input  logic [DW-1:0]  sp_in,
  input  logic [DW-1:0]  sr_in,
  output logic [DW-1:0]  result,
  output logic           result_we,
  output logic [DW-1:0]  sr_out,
  output logic [DW-1:0]  pc_out,
  output logic [DW-1:0]  sp_out,
  output logic           done,
  output logic           error,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);
  sop_code_e     code;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] alu_flags;
  logic          alu_sets;
  logic          busy;
  logic          unused_opc_bits;

  assign code            = sop_code_e'(opcode[OP_LSB+2:OP_LSB]);
  assign unused_opc_bits = ^{opcode[OPW-1:OP_LSB+3], opcode[OP_LSB-1:0]};

  sop_alu #(.DW(DW)) u_alu (
    .code       (code),
    .operand    (operand_in),
    .carry_in   (sr_in[FLG_C]),
    .res        (alu_res),
    .flags      (alu_flags),
    .sets_flags (alu_sets)
  );

  sop_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .code      (code),
    .operand   (operand_in),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .sr_in     (sr_in),
    .alu_res   (alu_res),
    .alu_flags (alu_flags),
    .alu_sets  (alu_sets),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .result    (result),
    .result_we (result_we),
    .sr_out    (sr_out),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .done      (done),
    .error     (error),
    .busy      (busy)
  );
endmodule

// File: rtl/sop_exec_chk.sv
module sop_exec_chk #(
  parameter int unsigned DW  = 16,
  parameter int unsigned OPW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic [OPW-1:0] opcode,
  input logic [DW-1:0]  operand_in,
  input logic [DW-1:0]  pc_in,
  input logic [DW-1:0]  sp_in,
  input logic [DW-1:0]  sr_in,
  input logic [DW-1:0]  result,
  input logic [DW-1:0]  sr_out,
  input logic           done,
  input logic           error,
  input logic           mem_req,
  input logic           mem_we,
  input logic [DW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_ack
);
  logic go;
  assign go = start && !busy;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && opcode[9:7] == 3'd7 |=> done && error && !mem_req);

  // R10
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R3
  swap_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && opcode[9:7] == 3'd1 |=> done &&
      result == {$past(operand_in[7:0]), $past(operand_in[15:8])} && sr_out == $past(sr_in));

  // R7
  push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && opcode[9:7] == 3'd4 |=> mem_req && mem_we &&
      mem_addr == $past(sp_in) - DW'(2) && mem_wdata == $past(operand_in));

  // R8
  call_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && opcode[9:7] == 3'd5 |=> mem_req && mem_we &&
      mem_addr == $past(sp_in) - DW'(2) && mem_wdata == $past(pc_in));

  // R9
  reti_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && opcode[9:7] == 3'd6 |=> mem_req && !mem_we && mem_addr == $past(sp_in));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done && !error);
endmodule

bind sop_exec sop_exec_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .opcode     (opcode),
  .operand_in (operand_in),
  .pc_in      (pc_in),
  .sp_in      (sp_in),
  .sr_in      (sr_in),
  .result     (result),
  .sr_out     (sr_out),
  .done       (done),
  .error      (error),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack)
);

// File: tb/tb_sop_exec.sv
module tb_sop_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = '0, operand_in = '0, pc_in = '0, sp_in = '0, sr_in = '0;
  logic [15:0] result, sr_out, pc_out, sp_out, mem_addr, mem_wdata;
  logic        result_we, done, error, mem_req, mem_we;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  sop_exec dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .operand_in(operand_in), .pc_in(pc_in), .sp_in(sp_in), .sr_in(sr_in),
    .result(result), .result_we(result_we), .sr_out(sr_out), .pc_out(pc_out),
    .sp_out(sp_out), .done(done), .error(error), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // memory responder: acknowledges one cycle after a request is seen
  logic [15:0] mem [0:255];
  int          acc_count = 0;
  logic [15:0] last_waddr = '0, last_wdata = '0;
  logic        poke_en = 1'b0;
  logic [15:0] poke_a = '0, poke_d = '0;

  always @(posedge clk) begin
    if (poke_en) mem[poke_a[8:1]] <= poke_d;
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[8:1]];
      acc_count <= acc_count + 1;
      if (mem_we) begin
        mem[mem_addr[8:1]] <= mem_wdata;
        last_waddr <= mem_addr;
        last_wdata <= mem_wdata;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  typedef struct {
    string       tag;
    logic [15:0] res;
    bit          res_we;
    logic [15:0] sr, pc, sp;
    bit          err;
    int          nacc;
    int          base;
    bit          wr;
    logic [15:0] waddr, wdata;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  function automatic logic [15:0] flg(logic [15:0] r, logic c);
    return {13'b0, r[15], (r == 16'h0), c};
  endfunction

  function automatic item_t model(string tag, logic [15:0] opc, logic [15:0] op,
                                  logic [15:0] pc, logic [15:0] sp, logic [15:0] sr,
                                  logic [15:0] m0, logic [15:0] m1);
    item_t it;
    logic [15:0] r;
    it.tag = tag; it.res = op; it.res_we = 1'b0; it.sr = sr; it.pc = pc; it.sp = sp;
    it.err = 1'b0; it.nacc = 0; it.base = 0; it.wr = 1'b0; it.waddr = '0; it.wdata = '0;
    case (opc[9:7])
      3'd0: begin r = {sr[0], op[15:1]}; it.res = r; it.res_we = 1; it.sr = flg(r, op[0]); end
      3'd1: begin it.res = {op[7:0], op[15:8]}; it.res_we = 1; end
      3'd2: begin r = {op[15], op[15:1]}; it.res = r; it.res_we = 1; it.sr = flg(r, op[0]); end
      3'd3: begin r = {{8{op[7]}}, op[7:0]}; it.res = r; it.res_we = 1; it.sr = flg(r, r != 0); end
      3'd4: begin it.sp = sp - 2; it.nacc = 1; it.wr = 1; it.waddr = sp - 2; it.wdata = op; end
      3'd5: begin it.sp = sp - 2; it.pc = op; it.nacc = 1; it.wr = 1; it.waddr = sp - 2; it.wdata = pc; end
      3'd6: begin it.sr = m0; it.pc = m1; it.sp = sp + 4; it.nacc = 2; end
      default: it.err = 1;
    endcase
    return it;
  endfunction

  task automatic fail(string tag, string what, logic [15:0] act, logic [15:0] exp);
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // monitor: pops the expected item when the design reports completion
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      item_t e;
      bit bad;
      bad = 0;
      vectors++;
      if (q.size() == 0) begin
        $display("FAIL R11 unexpected done actual=1 expected=0");
        miscompares++;
      end else begin
        e = q.pop_front();
        if (error !== e.err) begin fail(e.tag, "error", 16'(error), 16'(e.err)); bad = 1; end
        if (result_we !== e.res_we) begin fail(e.tag, "result_we", 16'(result_we), 16'(e.res_we)); bad = 1; end
        if (e.res_we && result !== e.res) begin fail(e.tag, "result", result, e.res); bad = 1; end
        if (sr_out !== e.sr) begin fail(e.tag, "sr", sr_out, e.sr); bad = 1; end
        if (pc_out !== e.pc) begin fail(e.tag, "pc", pc_out, e.pc); bad = 1; end
        if (sp_out !== e.sp) begin fail(e.tag, "sp", sp_out, e.sp); bad = 1; end
        if (acc_count - e.base != e.nacc) begin
          fail(e.tag, "access count", 16'(acc_count - e.base), 16'(e.nacc)); bad = 1;
        end
        if (e.wr && (last_waddr !== e.waddr || last_wdata !== e.wdata)) begin
          fail(e.tag, "write addr", last_waddr, e.waddr);
          fail(e.tag, "write data", last_wdata, e.wdata); bad = 1;
        end
        if (bad) miscompares++;
      end
    end
  end

  task automatic poke(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    poke_a = a; poke_d = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // driver: computes expectations, queues them, launches the instruction
  task automatic run(string tag, logic [15:0] opc, logic [15:0] op, logic [15:0] pc,
                     logic [15:0] sp, logic [15:0] sr,
                     logic [15:0] m0 = 16'h0, logic [15:0] m1 = 16'h0);
    item_t it;
    if (opc[9:7] == 3'd6) begin
      poke(sp, m0);
      poke(sp + 16'd2, m1);
    end
    it = model(tag, opc, op, pc, sp, sr, m0, m1);
    @(negedge clk);
    it.base = acc_count;
    q.push_back(it);
    opcode = opc; operand_in = op; pc_in = pc; sp_in = sp; sr_in = sr; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    do @(negedge clk); while (!done);
    @(negedge clk);
    vectors++;
    // R11 done lasts a single cycle
    if (done !== 1'b0) begin
      $display("FAIL R11 done pulse width actual=%b expected=0", done);
      miscompares++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    // R12 quiet outputs while in reset
    if (done !== 1'b0 || error !== 1'b0 || mem_req !== 1'b0) begin
      $display("FAIL R12 reset outputs actual=%b%b%b expected=000", done, error, mem_req);
      miscompares++;
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    vectors++;
    if (done !== 1'b0 || mem_req !== 1'b0) begin
      $display("FAIL R12 idle outputs actual=%b%b expected=00", done, mem_req);
      miscompares++;
    end

    run("R2 rotate carry-in 0",   16'h1000, 16'h8001, 16'h0100, 16'h0200, 16'h0000);
    run("R2 rotate carry-in 1",   16'h1000, 16'h0001, 16'h0100, 16'h0200, 16'h0107);
    run("R2 rotate to zero",      16'h1000, 16'h0001, 16'h0100, 16'h0200, 16'h0000);
    run("R3 byte swap",           16'h1080, 16'h12AB, 16'h0100, 16'h0200, 16'h0105);
    run("R4 shift negative",      16'h1100, 16'h8003, 16'h0100, 16'h0200, 16'h0000);
    run("R4 shift positive",      16'h1100, 16'h4002, 16'h0100, 16'h0200, 16'h0001);
    run("R5 extend bit7 set",     16'h1180, 16'h1280, 16'h0100, 16'h0200, 16'h0000);
    run("R5 extend bit7 clear",   16'h1180, 16'hFF7F, 16'h0100, 16'h0200, 16'h0000);
    run("R6 extend zero clears V",16'h1180, 16'hAB00, 16'h0100, 16'h0200, 16'h01FF);
    run("R7 push",                16'h1200, 16'hBEEF, 16'h0100, 16'h0100, 16'h0104);
    run("R8 call",                16'h1280, 16'h4400, 16'h2222, 16'h0080, 16'h0003);
    run("R9 return from interrupt", 16'h1300, 16'h0000, 16'h5555, 16'h0040, 16'h0000,
        16'h0104, 16'h3456);
    run("R10 illegal code",       16'h1380, 16'h7777, 16'h1234, 16'h0060, 16'h0102);
    run("R1 other opcode bits",   16'hF07F, 16'h0003, 16'h0100, 16'h0200, 16'h0001);
    run("R1 other bits swap",     16'hFCC5, 16'h00FF, 16'h0100, 16'h0200, 16'h0000);
    run("R7 push after pop",      16'h1200, 16'h0042, 16'h0100, 16'h0044, 16'h0000);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    vectors++;
    if (q.size() != 0) begin
      $display("FAIL R11 pending results actual=%0d expected=0", q.size());
      miscompares++;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule